// File: doc/BRIEF.md
# LCD Vertical Timing Generator

This block sequences the vertical part of an LCD frame. It advances one line at a time, driven by a one-cycle line pulse from a horizontal timing stage. Each frame runs through four phases in a fixed order: visible lines, front porch, sync period, back porch. Then the next frame begins. While the generator is in the visible phase, it raises a flag that enables pixel output and gives a zero-based line index.

The timing settings come from one 32-bit word, written through a simple write strobe. A written word is held as pending. It takes effect only on the line pulse that starts a new visible phase, so the geometry of a frame in progress never changes. A mode input selects a panel type with a sync pulse or one without. In the second type, the sync period is still spent as dummy lines, but no pulse is driven.

Top module: `lcd_vtiming_gen`

## Requirements
- R1: After reset, the generator waits in the back porch phase with `fsync_o` low, `vactive_o` low and `line_idx_o` zero. The first line pulse starts the visible phase and loads the pending word.
- R2: Bits 9:0 hold the visible line count minus one (value N gives N+1 lines). The visible phase lasts N+1 line pulses.
- R3: During the visible phase, `line_idx_o` starts at 0 and increments on each line pulse up to N. Outside the visible phase it reads 0.
- R4: Bits 23:16 set the front porch length in line pulses (0 to 255). The front porch follows the last visible line, and a value of 0 skips it entirely.
- R5: Bits 15:10 hold the sync period length minus one (value S gives S+1 line pulses). The sync period follows the front porch.
- R6: With `mode_passive_i` = 0, `fsync_o` is high exactly while the sync period lasts, and low at all other times.
- R7: With `mode_passive_i` = 1, the sync period still takes S+1 line pulses, but `fsync_o` stays low.
- R8: Bits 31:24 set the back porch length in line pulses (0 to 255). The back porch follows the sync period, and a value of 0 moves straight on to the next visible phase.
- R9: A written word has no effect on the current frame. The working settings change only on the line pulse that begins a visible phase.
- R10: If a write arrives in the same cycle as a frame-starting line pulse, the new frame uses the word written in that cycle.
- R11: The phase and line position change only in cycles where `line_tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_tick_i | input | 1 | One-cycle pulse per line period |
| mode_passive_i | input | 1 | 1 selects the panel type without a sync pulse |
| cfg_we_i | input | 1 | Write strobe for the timing word |
| cfg_wdata_i | input | 32 | Timing word (field layout per R2, R4, R5, R8) |
| fsync_o | output | 1 | Frame sync pulse |
| vactive_o | output | 1 | High during visible lines |
| line_idx_o | output | 10 | Visible line index |

## Verification
A register write and a frame-starting line pulse can land in the same cycle. It is the one case where a pending word and a freshly written word compete for the working copy. The bench tracks its own model of the phase. Whenever the next line pulse would end the back porch, or end the sync period with a zero back porch, the bench fires a write with randomised field values in that cycle. Every following line of the frame is then compared against the geometry of the word written in that cycle, not the word that was pending before it.

// File: rtl/lcd_vt_pkg.sv
package lcd_vt_pkg;
  localparam int LPS_W = 10;
  localparam int VSW_W = 6;
  localparam int FP_W  = 8;
  localparam int BP_W  = 8;
  localparam int CFG_W = LPS_W + VSW_W + FP_W + BP_W;
  localparam int CNT_W = LPS_W;

  typedef enum logic [1:0] {
    PH_ACT  = 2'd0,
    PH_FP   = 2'd1,
    PH_SYNC = 2'd2,
    PH_BP   = 2'd3
  } phase_e;

  // msb first: bp 31:24, fp 23:16, vsw 15:10, lps 9:0
  typedef struct packed {
    logic [BP_W-1:0]  bp;
    logic [FP_W-1:0]  fp;
    logic [VSW_W-1:0] vsw;
    logic [LPS_W-1:0] lps;
  } vcfg_t;
endpackage

// File: rtl/lcd_vt_cfg.sv
module lcd_vt_cfg
  import lcd_vt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  vcfg_t wdata_i,
  input  logic  load_i,
  output vcfg_t work_o
);
  vcfg_t pend_q;
  vcfg_t work_q;
  vcfg_t load_val;

  // same-cycle write wins over the older pending word
  assign load_val = we_i ? wdata_i : pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (we_i) begin
      pend_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q <= '0;
    end else if (load_i) begin
      work_q <= load_val;
    end
  end

  assign work_o = work_q;

  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(work_o));

  p_cfg_bypass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && we_i) |=> (work_o == $past(wdata_i)));
endmodule

// File: rtl/lcd_vt_seq.sv
module lcd_vt_seq
  import lcd_vt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  vcfg_t            cfg_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o
);
  localparam int EXT_W = CNT_W + 1;

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXT_W-1:0] cnt_p1;
  logic             end_act, end_fp, end_sync, end_bp;
  logic             fp_zero, bp_zero;

  assign cnt_p1   = {1'b0, cnt_q} + EXT_W'(1);
  assign end_act  = (cnt_q == cfg_i.lps);
  assign end_fp   = (cnt_p1 >= EXT_W'(cfg_i.fp));
  assign end_sync = (cnt_q == CNT_W'(cfg_i.vsw));
  // bp of zero only seen in the reset wait: first tick ends it
  assign end_bp   = (cnt_p1 >= EXT_W'(cfg_i.bp));
  assign fp_zero  = (cfg_i.fp == '0);
  assign bp_zero  = (cfg_i.bp == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    load_o  = 1'b0;
    if (tick_i) begin
      cnt_d = cnt_q + CNT_W'(1);
      unique case (phase_q)
        PH_ACT: if (end_act) begin
          phase_d = fp_zero ? PH_SYNC : PH_FP;
          cnt_d   = '0;
        end
        PH_FP: if (end_fp) begin
          phase_d = PH_SYNC;
          cnt_d   = '0;
        end
        PH_SYNC: if (end_sync) begin
          cnt_d = '0;
          if (bp_zero) begin
            phase_d = PH_ACT;
            load_o  = 1'b1;
          end else begin
            phase_d = PH_BP;
          end
        end
        PH_BP: if (end_bp) begin
          phase_d = PH_ACT;
          cnt_d   = '0;
          load_o  = 1'b1;
        end
        default: begin
          phase_d = PH_BP;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_BP;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;

  p_stable_no_tick_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(phase_o) && $stable(cnt_o)));

  p_idx_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_ACT) |-> (cnt_o <= cfg_i.lps));

  p_sync_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_SYNC) |-> (cnt_o <= CNT_W'(cfg_i.vsw)));
endmodule

// File: rtl/lcd_vt_out.sv
module lcd_vt_out
  import lcd_vt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           phase_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             passive_i,
  output logic             fsync_o,
  output logic             vactive_o,
  output logic [CNT_W-1:0] line_idx_o
);
  assign vactive_o  = (phase_i == PH_ACT);
  assign line_idx_o = vactive_o ? cnt_i : '0;
  assign fsync_o    = (phase_i == PH_SYNC) && !passive_i;

  p_sync_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o |-> !vactive_o);

  p_idx_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vactive_o |-> (line_idx_o == '0));
endmodule

// File: rtl/lcd_vtiming_gen.sv
module lcd_vtiming_gen
  import lcd_vt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_tick_i,
  input  logic             mode_passive_i,
  input  logic             cfg_we_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic             fsync_o,
  output logic             vactive_o,
  output logic [LPS_W-1:0] line_idx_o
);
  vcfg_t            work;
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             load;

  lcd_vt_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (vcfg_t'(cfg_wdata_i[CFG_W-1:0])),
    .load_i  (load),
    .work_o  (work)
  );

  lcd_vt_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (line_tick_i),
    .cfg_i   (work),
    .phase_o (phase),
    .cnt_o   (cnt),
    .load_o  (load)
  );

  lcd_vt_out u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase),
    .cnt_i      (cnt),
    .passive_i  (mode_passive_i),
    .fsync_o    (fsync_o),
    .vactive_o  (vactive_o),
    .line_idx_o (line_idx_o)
  );

  p_passive_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_passive_i |-> !fsync_o);

  p_entry_idx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vactive_o) |-> (line_idx_o == '0));

  p_load_enters_act_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (vactive_o && line_idx_o == '0));
endmodule

// File: tb/lcd_vtiming_gen_tb.sv
module lcd_vtiming_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        line_tick_i = 1'b0;
  logic        mode_passive_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic        fsync_o, vactive_o;
  logic [9:0]  line_idx_o;

  always #2.5 clk_i = ~clk_i;

  lcd_vtiming_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_tick_i(line_tick_i),
    .mode_passive_i(mode_passive_i), .cfg_we_i(cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i), .fsync_o(fsync_o), .vactive_o(vactive_o),
    .line_idx_o(line_idx_o)
  );

  int n_cmp = 0, n_bad = 0, n_coinc = 0;
  // model: 0 visible, 1 front porch, 2 sync, 3 back porch
  int m_ph = 3, m_cnt = 0, w_lps = 0, w_vsw = 0, w_fp = 0, w_bp = 0;
  logic [31:0] m_pend = '0;
  bit m_pass = 0;

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit about_to_start();
    return (m_ph == 3 && m_cnt + 1 >= w_bp) ||
           (m_ph == 2 && m_cnt == w_vsw && w_bp == 0);
  endfunction

  task automatic model_step(bit t, bit w, logic [31:0] d);
    logic [31:0] lv;
    bit start;
    lv = w ? d : m_pend;
    start = 0;
    if (t) begin
      case (m_ph)
        0: if (m_cnt == w_lps) begin m_ph = (w_fp > 0) ? 1 : 2; m_cnt = 0; end
           else m_cnt++;
        1: if (m_cnt + 1 >= w_fp) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
        2: if (m_cnt == w_vsw) begin
             if (w_bp > 0) begin m_ph = 3; m_cnt = 0; end else start = 1;
           end else m_cnt++;
        default: if (m_cnt + 1 >= w_bp) start = 1; else m_cnt++;
      endcase
      if (start) begin
        m_ph = 0; m_cnt = 0;
        w_lps = int'(lv[9:0]); w_vsw = int'(lv[15:10]);
        w_fp = int'(lv[23:16]); w_bp = int'(lv[31:24]);
      end
    end
    if (w) m_pend = d;
  endtask

  task automatic compare();
    check("R2/R4/R8/R9", int'(vactive_o), int'(m_ph == 0));
    check("R3/R11", int'(line_idx_o), (m_ph == 0) ? m_cnt : 0);
    check("R5/R6/R7", int'(fsync_o), int'(m_ph == 2 && !m_pass));
  endtask

  task automatic cycle(bit t, bit w, logic [31:0] d, bit p);
    @(negedge clk_i);
    compare();
    if (t && w && about_to_start()) n_coinc++;
    line_tick_i = t; cfg_we_i = w; cfg_wdata_i = d; mode_passive_i = p;
    model_step(t, w, d);
    m_pass = p;
  endtask

  function automatic logic [31:0] mk(int lps, int vsw, int fp, int bp);
    return {8'(bp), 8'(fp), 6'(vsw), 10'(lps)};
  endfunction

  function automatic logic [31:0] rnd_cfg();
    return mk($urandom % 6, $urandom % 4, $urandom % 4, $urandom % 4);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1", int'(fsync_o), 0);
    check("R1", int'(vactive_o), 0);
    check("R1", int'(line_idx_o), 0);
    rst_ni = 1'b1;
    // pending word written before first tick, applied on first tick (R1, R2)
    cycle(0, 1, mk(4, 1, 2, 3), 0);
    cycle(0, 0, '0, 0);
    for (int i = 0; i < 60; i++) cycle(1, 0, '0, 0);
    // sparse ticks (R11)
    for (int i = 0; i < 80; i++) cycle(($urandom % 3) == 0, 0, '0, 0);
    // mid-frame write, zero porches (R4, R8, R9)
    for (int i = 0; i < 3; i++) cycle(1, 0, '0, 0);
    cycle(0, 1, mk(2, 0, 0, 0), 0);
    for (int i = 0; i < 60; i++) cycle(1, 0, '0, 0);
    // passive mode (R7)
    cycle(1, 1, mk(3, 2, 1, 1), 1);
    for (int i = 0; i < 60; i++) cycle(1, 0, '0, 1);
    // writes landing on frame start (R10)
    for (int i = 0; i < 400; i++) begin
      bit t, w;
      t = ($urandom % 2) == 0;
      w = (t && about_to_start()) || (($urandom % 17) == 0);
      cycle(t, w, rnd_cfg(), ($urandom % 5) == 0);
    end
    check("R10", int'(n_coinc > 0), 1);
    // field extremes (R2, R4, R5, R8)
    cycle(1, 1, mk(1023, 63, 255, 255), 0);
    for (int i = 0; i < 3700; i++) cycle(1, 0, '0, 0);
    for (int i = 0; i < 4; i++) cycle(0, 0, '0, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule